// File: doc/BRIEF.md
# Sleep and Interrupt Wake Controller

This block sequences power-down for a small processor core that runs every instruction over four clock phases. The decoder tells it when a sleep instruction or a watchdog-clear instruction is executing. It also receives the global interrupt enable and a set of interrupt flag/enable pairs. From these it decides whether the sleep instruction really puts the core to sleep or only acts as a no-operation. It drives the clear pulses for the external watchdog counter and its scalers and keeps the time-out and power-down status bits. While the core sleeps, it holds instruction fetch.

When a wake request ends sleep, the instruction that was already fetched runs first. If the global enable was set at wake time, the block then inserts a dummy cycle and requests a jump to the interrupt vector. If the enable was clear, execution continues in line with no jump. Software can detect the no-operation outcome because the power-down bit still reads 1 after the sleep instruction.

Top module: `swc_sleep_ctrl`

## Requirements
- R1: A wake request exists when at least one source has both its flag bit and its enable bit at 1. This holds whatever the value of `gie`. A flag with its enable at 0 raises no request.
- R2: If a wake request is present at the Q2 edge of a sleep instruction cycle (`sleep_op` high from Q1 through Q4), the instruction acts as a no-operation. No clear pulse occurs, `to_bit` and `pd_bit` do not change, and `asleep` stays 0.
- R3: Otherwise the sleep commits at the Q4 edge. From the next clock, `asleep`, `fetch_stall`, `cnt_clr`, `pre_clr` and `post_clr` are 1, with `to_bit`=1 and `pd_bit`=0. The three clear pulses last exactly one clock.
- R4: While `asleep` is 1, `qphase` stays at 0 (Q1) and `fetch_stall` stays 1. A wake request clears `asleep` and `fetch_stall` on the next clock edge.
- R5: After wake, `qphase` starts at Q1. One full instruction cycle of four clocks follows, with `redirect` low and fetch not stalled.
- R6: If `gie` was 1 at the wake edge, the next instruction cycle is a dummy cycle. During it `redirect` is 1 for four clocks and `redirect_addr` equals VEC_ADDR (default 4); after it `redirect` returns to 0. If `gie` was 0, `redirect` stays 0.
- R7: A watchdog-clear instruction cycle (`wdtclr_op` high from Q1 to Q4) gives a one-clock pulse on all three clear outputs after its Q4 edge. It leaves `to_bit` and `pd_bit` unchanged.
- R8: After reset, `to_bit`=1, `pd_bit`=1, `qphase`=0 and every other output is 0. A synchronous `sts_rst` sets `to_bit` and `pd_bit` to 1.
- R9: Outside sleep, `qphase` advances 0,1,2,3,0 by one on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sts_rst | input | 1 | Synchronous set of TO and PD status bits |
| sleep_op | input | 1 | Sleep instruction executing this instruction cycle |
| wdtclr_op | input | 1 | Watchdog-clear instruction executing this instruction cycle |
| gie | input | 1 | Global interrupt enable |
| irq_flag | input | N_SRC | Interrupt flag bits |
| irq_en | input | N_SRC | Interrupt enable bits |
| qphase | output | 2 | Current phase, 0..3 for Q1..Q4 |
| asleep | output | 1 | Core is in sleep |
| fetch_stall | output | 1 | Hold instruction fetch and program counter |
| cnt_clr | output | 1 | Watchdog counter clear pulse |
| pre_clr | output | 1 | Watchdog prescaler clear pulse |
| post_clr | output | 1 | Watchdog postscaler clear pulse |
| to_bit | output | 1 | Time-out status bit |
| pd_bit | output | 1 | Power-down status bit |
| redirect | output | 1 | Dummy cycle: fetch from the vector |
| redirect_addr | output | PC_W | Vector address |

## Verification
The assertions assume that the decoder holds `sleep_op` and `wdtclr_op` for a whole instruction cycle, aligned from Q1 to Q4. They also assume the two never overlap and that neither is issued during the post-wake or dummy cycles. The stimulus waits for `qphase` to read Q1 before it raises either strobe, keeps it for exactly four clocks, and issues no instruction until the redirect window has closed. The sweep covers every source, both enable values, and every arrival phase of the wake request: with the strobe, before Q2, Q3 or Q4, and during sleep. Disabled sources keep their flags set the whole time.

// File: rtl/swc_pkg.sv
package swc_pkg;
   typedef enum logic [1:0] {Q1 = 2'd0, Q2 = 2'd1, Q3 = 2'd2, Q4 = 2'd3} qph_t;
   typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_RESUME, ST_DUMMY} swc_st_t;
endpackage

// File: rtl/swc_qphase.sv
module swc_qphase
   import swc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output qph_t ph
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= Q1;
      else if (!hold)
         ph <= qph_t'(ph + 2'd1);
   end
endmodule

// File: rtl/swc_pend.sv
module swc_pend #(
   parameter int N_SRC = 8
) (
   input  logic [N_SRC-1:0] flag,
   input  logic [N_SRC-1:0] en,
   output logic             req
);
   logic [N_SRC-1:0] hit;
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign hit[i] = flag[i] & en[i];
   end
   assign req = |hit;
endmodule

// File: rtl/swc_status.sv
module swc_status #(
   parameter bit PRE_EN  = 1'b1,
   parameter bit POST_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sts_rst,
   input  logic commit,
   input  logic wclr,
   output logic cnt_clr,
   output logic pre_clr,
   output logic post_clr,
   output logic to_bit,
   output logic pd_bit
);
   logic clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q  <= 1'b0;
         to_bit <= 1'b1;
         pd_bit <= 1'b1;
      end else begin
         clr_q <= commit | wclr;
         if (sts_rst) begin
            to_bit <= 1'b1;
            pd_bit <= 1'b1;
         end else if (commit) begin
            to_bit <= 1'b1;
            pd_bit <= 1'b0;
         end
      end
   end

   assign cnt_clr = clr_q;

   if (PRE_EN) begin : g_pre
      assign pre_clr = clr_q;
   end else begin : g_nopre
      assign pre_clr = 1'b0;
   end

   if (POST_EN) begin : g_post
      assign post_clr = clr_q;
   end else begin : g_nopost
      assign post_clr = 1'b0;
   end

   // R8
   to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sts_rst) |-> (to_bit && pd_bit));
endmodule

// File: rtl/swc_sleep_ctrl.sv
module swc_sleep_ctrl
   import swc_pkg::*;
#(
   parameter int N_SRC    = 8,
   parameter int PC_W     = 13,
   parameter int VEC_ADDR = 4,
   parameter bit PRE_EN   = 1'b1,
   parameter bit POST_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sts_rst,
   input  logic              sleep_op,
   input  logic              wdtclr_op,
   input  logic              gie,
   input  logic [N_SRC-1:0]  irq_flag,
   input  logic [N_SRC-1:0]  irq_en,
   output logic [1:0]        qphase,
   output logic              asleep,
   output logic              fetch_stall,
   output logic              cnt_clr,
   output logic              pre_clr,
   output logic              post_clr,
   output logic              to_bit,
   output logic              pd_bit,
   output logic              redirect,
   output logic [PC_W-1:0]   redirect_addr
);
   localparam logic [PC_W-1:0] VEC_L = VEC_ADDR[PC_W-1:0];

   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_src
      $error("swc_sleep_ctrl: N_SRC must be 1..64");
   end
   if (PC_W < 3 || PC_W > 30) begin : g_bad_pcw
      $error("swc_sleep_ctrl: PC_W must be 3..30");
   end
   if (VEC_ADDR < 0 || VEC_ADDR >= (1 << PC_W)) begin : g_bad_vec
      $error("swc_sleep_ctrl: VEC_ADDR does not fit PC_W");
   end

   qph_t    ph;
   swc_st_t st;
   logic    wake_req;
   logic    nop_q;
   logic    vec_q;
   logic    commit;
   logic    wclr;

   swc_qphase u_ph (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (st == ST_SLEEP),
      .ph    (ph)
   );

   swc_pend #(.N_SRC(N_SRC)) u_pend (
      .flag (irq_flag),
      .en   (irq_en),
      .req  (wake_req)
   );

   assign commit = (st == ST_RUN) && (ph == Q4) && sleep_op && !nop_q;
   assign wclr   = (st == ST_RUN) && (ph == Q4) && wdtclr_op;

   swc_status #(.PRE_EN(PRE_EN), .POST_EN(POST_EN)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .sts_rst  (sts_rst),
      .commit   (commit),
      .wclr     (wclr),
      .cnt_clr  (cnt_clr),
      .pre_clr  (pre_clr),
      .post_clr (post_clr),
      .to_bit   (to_bit),
      .pd_bit   (pd_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_RUN;
         nop_q <= 1'b0;
         vec_q <= 1'b0;
      end else begin
         case (st)
            ST_RUN: begin
               if (ph == Q1)
                  nop_q <= 1'b0;
               else if (ph == Q2 && sleep_op)
                  nop_q <= wake_req;
               if (commit)
                  st <= ST_SLEEP;
            end
            ST_SLEEP: begin
               if (wake_req) begin
                  st    <= ST_RESUME;
                  vec_q <= gie;
               end
            end
            ST_RESUME: begin
               if (ph == Q4)
                  st <= vec_q ? ST_DUMMY : ST_RUN;
            end
            default: begin
               if (ph == Q4)
                  st <= ST_RUN;
            end
         endcase
      end
   end

   assign qphase        = ph;
   assign asleep        = (st == ST_SLEEP);
   assign fetch_stall   = asleep;
   assign redirect      = (st == ST_DUMMY);
   assign redirect_addr = redirect ? VEC_L : '0;

   // R4
   sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && wake_req) |=> (!asleep && !fetch_stall && qphase == 2'd0));
   // R4
   sleep_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> (qphase == 2'd0));
   // R2
   nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == Q4 && nop_q) |=> (!asleep && !cnt_clr && $stable(pd_bit) && $stable(to_bit)));
   // R3
   clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> !cnt_clr);
   // R3
   pd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_bit) |-> (asleep && cnt_clr));
   // R6
   redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(redirect) |-> ($past(st) == ST_RESUME && vec_q));
endmodule

// File: tb/swc_sleep_ctrl_test.sv
`timescale 1ns/1ps
module swc_sleep_ctrl_test;
   localparam int N   = 8;
   localparam int PCW = 13;
   localparam int VEC = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sts_rst = 1'b0;
   logic           sleep_op = 1'b0;
   logic           wdtclr_op = 1'b0;
   logic           gie = 1'b0;
   logic [N-1:0]   irq_flag = '0;
   logic [N-1:0]   irq_en = '0;
   logic [1:0]     qphase;
   logic           asleep, fetch_stall, cnt_clr, pre_clr, post_clr;
   logic           to_bit, pd_bit, redirect;
   logic [PCW-1:0] redirect_addr;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   swc_sleep_ctrl #(.N_SRC(N), .PC_W(PCW), .VEC_ADDR(VEC)) uut (
      .clk(clk), .rst_n(rst_n), .sts_rst(sts_rst), .sleep_op(sleep_op),
      .wdtclr_op(wdtclr_op), .gie(gie), .irq_flag(irq_flag), .irq_en(irq_en),
      .qphase(qphase), .asleep(asleep), .fetch_stall(fetch_stall),
      .cnt_clr(cnt_clr), .pre_clr(pre_clr), .post_clr(post_clr),
      .to_bit(to_bit), .pd_bit(pd_bit), .redirect(redirect),
      .redirect_addr(redirect_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_q1();
      @(negedge clk);
      while (qphase != 2'd0) @(negedge clk);
   endtask

   task automatic status_reset();
      @(negedge clk);
      sts_rst = 1'b1;
      @(negedge clk);
      sts_rst = 1'b0;
   endtask

   // arrival a: 0 with strobe, 1..3 before edge a+1, 4 during sleep
   task automatic run_case(input int a, input bit g, input int s);
      logic [N-1:0] mask;
      mask = N'(1) << s;
      status_reset();
      irq_en   = mask;
      irq_flag = ~mask;      // R1: flags of disabled sources stay set
      gie      = g;
      wait_q1();
      sleep_op = 1'b1;
      if (a == 0) irq_flag = '1;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (k < 4 && a == k) irq_flag = '1;
      end
      sleep_op = 1'b0;
      if (a <= 1) begin
         chk("R2 asleep", asleep, 0);
         chk("R2 cnt_clr", cnt_clr, 0);
         chk("R2 to_bit", to_bit, 1);
         chk("R2 pd_bit", pd_bit, 1);
         irq_flag = '0;
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R2 redirect", redirect, 0);
         end
      end else begin
         chk("R3 asleep", asleep, 1);
         chk("R3 clr", {cnt_clr, pre_clr, post_clr}, 3'b111);
         chk("R3 to_bit", to_bit, 1);
         chk("R3 pd_bit", pd_bit, 0);
         chk("R4 stall", fetch_stall, 1);
         if (a == 4) begin
            repeat (5) @(negedge clk);
            chk("R1 no wake from disabled flags", asleep, 1);
            chk("R4 phase held", qphase, 0);
            chk("R3 clr ends", cnt_clr, 0);
            irq_flag = '1;
         end
         @(negedge clk);
         chk("R4 wake", asleep, 0);
         chk("R4 stall off", fetch_stall, 0);
         chk("R5 phase Q1", qphase, 0);
         irq_flag = '0;
         for (int i = 0; i <= 8; i++) begin
            bit expv;
            expv = g && (i >= 4) && (i <= 7);
            if (i < 4) chk("R5 no redirect", redirect, 0);
            else       chk("R6 redirect", redirect, expv);
            if (expv)  chk("R6 addr", redirect_addr, VEC);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R8 to", to_bit, 1);
      chk("R8 pd", pd_bit, 1);
      chk("R8 outs", {asleep, fetch_stall, cnt_clr, pre_clr, post_clr, redirect}, 0);
      chk("R8 phase", qphase, 0);
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         chk("R9 phase step", qphase, 32'(i % 4));
      end
      // R7 watchdog clear
      wait_q1();
      wdtclr_op = 1'b1;
      repeat (4) @(negedge clk);
      wdtclr_op = 1'b0;
      chk("R7 clr", {cnt_clr, pre_clr, post_clr}, 3'b111);
      chk("R7 to/pd", {to_bit, pd_bit}, 2'b11);
      @(negedge clk);
      chk("R7 clr one clock", cnt_clr, 0);
      for (int a = 0; a <= 4; a++)
         for (int g = 0; g <= 1; g++)
            for (int s = 0; s < N; s++)
               run_case(a, g[0], s);
      // R7 leaves cleared PD untouched after a sleep
      run_case(4, 1'b0, 0);
      wait_q1();
      wdtclr_op = 1'b1;
      repeat (4) @(negedge clk);
      wdtclr_op = 1'b0;
      chk("R7 clr after sleep", cnt_clr, 1);
      chk("R7 pd kept", {to_bit, pd_bit}, 2'b10);
      // R8 status reset
      status_reset();
      chk("R8 sts_rst", {to_bit, pd_bit}, 2'b11);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule